// File: doc/BRIEF.md
# Codec Interrupt Cause and Page Select Register

This block is a single 16-bit control and status word for the audio half of a codec. Two event sources feed it: a jack-sense engine that pulses when a measurement finishes, and a GPIO monitor that pulses when an input pin changes level. Any event sets a pending flag and records the kind of the first event in a two-bit cause field. Software reads the word to find out why the codec interrupted. It clears the flag by writing a one to the same position.

The same word holds three more controls. A write-one-to-start bit launches a sense measurement and reads back as busy until the engine reports completion. An enable bit gates the pending flag onto the interrupt output, which feeds the general-purpose-input bit of link slot 12. A four-bit page selector chooses which bank of paged registers the rest of the codec exposes.

The register port is a plain strobe with no back-pressure. A write is taken in the cycle `reg_wr` is high, and read data is always valid. The event inputs and `sense_done` are single-cycle pulses. When the parameter `SENSE_SUPPORTED` is 0, the sense start bit reads 0, ignores writes and never pulses `sense_start`.

Top module: `codec_irq_page_reg`

## Requirements
- R1: After reset, `reg_rdata` reads 16'h0000 and both `sense_start` and `slot12_gpi` are low.
- R2: An event pulse on `sense_done` or `gpio_change` sets bit 15 (pending) on the next clock, whatever the value of bit 11 (enable).
- R3: A write with bit 15 = 1 and no event in that cycle clears bit 15 and sets bits 14:13 to 00. A write with bit 15 = 0 leaves both unchanged.
- R4: When an event sets pending from the cleared state, bits 14:13 become 01 for a sense completion only, 10 for a GPIO change only, and 11 when both arrive in the same cycle.
- R5: While pending is set and not being cleared, later events leave bits 14:13 unchanged.
- R6: When an event arrives in the same cycle as a write-one-to-clear, pending stays 1 and bits 14:13 take the code of the new event.
- R7: A write with bit 12 = 1 while no sense cycle is running drives `sense_start` high for exactly the next cycle. From that cycle on, bit 12 reads 1 until the clock after a `sense_done` pulse.
- R8: A write with bit 12 = 1 while a sense cycle runs does not pulse `sense_start`. A write with bit 12 = 0 does not start or stop a cycle.
- R9: Bit 11 takes the written value on every write. `slot12_gpi` equals bit 15 AND bit 11.
- R10: Bits 3:0 take the written page value on every write and read it back.
- R11: Bits 10:4 always read 0, whatever is written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Current register value |
| sense_done | input | 1 | Pulse: sense measurement finished (also an event) |
| gpio_change | input | 1 | Pulse: a GPIO input changed |
| sense_start | output | 1 | One-cycle pulse that launches a sense cycle |
| slot12_gpi | output | 1 | Interrupt toward the slot-12 GPI bit |

## Verification
The read word shows every stored bit, so a wrong flag, cause, busy, enable or page value appears on `reg_rdata` in the cycle after the edge that stored it. The bench also compares `sense_start` and `slot12_gpi` on every clock. A pulse that is lost, doubled or mis-gated is therefore seen within one cycle. The stimulus covers the races that hide faults in this kind of register: an event that collides with a clear, two sources that fire together, and a start request while a sense cycle is running.

// File: rtl/cip_pkg.sv
package cip_pkg;
  localparam int REG_W     = 16;
  localparam int PEND_BIT  = 15;
  localparam int CAUSE_HI  = 14;
  localparam int CAUSE_LO  = 13;
  localparam int SENSE_BIT = 12;
  localparam int IEN_BIT   = 11;

  // cause code: bit0 = sense completion, bit1 = GPIO change
  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'b00,
    CAUSE_SENSE = 2'b01,
    CAUSE_GPIO  = 2'b10,
    CAUSE_BOTH  = 2'b11
  } cause_e;
endpackage

// File: rtl/cip_irq_status.sv
module cip_irq_status
  import cip_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   clr_req,
  input  logic   ev_sense,
  input  logic   ev_gpio,
  output logic   pending,
  output cause_e cause
);
  logic any_ev;
  logic capture;
  assign any_ev  = ev_sense | ev_gpio;
  // an event captures the cause when nothing is pending or the old one is being acknowledged
  assign capture = any_ev & (~pending | clr_req);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
      cause   <= CAUSE_NONE;
    end else begin
      if (any_ev)       pending <= 1'b1;
      else if (clr_req) pending <= 1'b0;

      if (capture)      cause <= cause_e'({ev_gpio, ev_sense});
      else if (clr_req) cause <= CAUSE_NONE;
    end
  end

  a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    any_ev |=> pending);
  a_r4_cause_valid: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> (cause != CAUSE_NONE));
  a_r5_cause_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !clr_req) |=> $stable(cause));
  a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !any_ev) |=> (!pending && cause == CAUSE_NONE));
endmodule

// File: rtl/cip_sense_ctrl.sv
module cip_sense_ctrl #(
  parameter bit SUPPORTED = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic done,
  output logic busy,
  output logic start_pulse
);
  generate
    if (SUPPORTED) begin : g_sense
      logic launch;
      assign launch = start_req & ~busy;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          busy        <= 1'b0;
          start_pulse <= 1'b0;
        end else begin
          start_pulse <= launch;
          if (launch)    busy <= 1'b1;
          else if (done) busy <= 1'b0;
        end
      end

      a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> !start_pulse);
      a_r7_busy_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> busy);
      a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> !start_pulse);
    end else begin : g_nosense
      logic unused_inputs;
      assign unused_inputs = start_req ^ done ^ clk ^ rst_n;
      assign busy        = 1'b0;
      assign start_pulse = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/cip_ctrl_fields.sv
module cip_ctrl_fields #(
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              ien_in,
  input  logic [PAGE_W-1:0] page_in,
  output logic              ien,
  output logic [PAGE_W-1:0] page
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien  <= 1'b0;
      page <= '0;
    end else if (wr) begin
      ien  <= ien_in;
      page <= page_in;
    end
  end

  a_r10_page_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (page == $past(page_in)));
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> ($stable(ien) && $stable(page)));
endmodule

// File: rtl/codec_irq_page_reg.sv
module codec_irq_page_reg
  import cip_pkg::*;
#(
  parameter bit SENSE_SUPPORTED = 1'b1,
  parameter int PAGE_W          = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic        sense_done,
  input  logic        gpio_change,
  output logic        sense_start,
  output logic        slot12_gpi
);
  localparam int RSV_W = IEN_BIT - PAGE_W;

  logic              pending;
  cause_e            cause;
  logic              busy;
  logic              ien;
  logic [PAGE_W-1:0] page;
  logic              clr_req;
  logic              start_req;
  logic              unused_rsv;

  assign clr_req    = reg_wr & reg_wdata[PEND_BIT];
  assign start_req  = reg_wr & reg_wdata[SENSE_BIT];
  assign unused_rsv = ^reg_wdata[IEN_BIT-1:PAGE_W];

  cip_irq_status u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_req  (clr_req),
    .ev_sense (sense_done),
    .ev_gpio  (gpio_change),
    .pending  (pending),
    .cause    (cause)
  );

  cip_sense_ctrl #(.SUPPORTED(SENSE_SUPPORTED)) u_sense (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_req   (start_req),
    .done        (sense_done),
    .busy        (busy),
    .start_pulse (sense_start)
  );

  cip_ctrl_fields #(.PAGE_W(PAGE_W)) u_fields (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (reg_wr),
    .ien_in  (reg_wdata[IEN_BIT]),
    .page_in (reg_wdata[PAGE_W-1:0]),
    .ien     (ien),
    .page    (page)
  );

  assign reg_rdata  = {pending, cause, busy, ien, {RSV_W{1'b0}}, page};
  assign slot12_gpi = pending & ien;

  a_r9_masked: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rdata[IEN_BIT] |-> !slot12_gpi);
  a_r11_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[IEN_BIT-1:PAGE_W] == '0);
endmodule

// File: tb/codec_irq_page_reg_tb_top.sv
`timescale 1ns/1ps
module codec_irq_page_reg_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;
  logic        sense_done = 1'b0;
  logic        gpio_change = 1'b0;
  logic        sense_start;
  logic        slot12_gpi;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // behavioural reference state
  int m_stat = 0, m_cause = 0, m_busy = 0, m_en = 0, m_page = 0, m_start = 0;

  always #2 clk = ~clk;

  codec_irq_page_reg dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .sense_done(sense_done), .gpio_change(gpio_change),
    .sense_start(sense_start), .slot12_gpi(slot12_gpi)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_stat = 0; m_cause = 0; m_busy = 0; m_en = 0; m_page = 0; m_start = 0;
    end else begin
      int ev, clr, go;
      ev  = (sense_done || gpio_change) ? 1 : 0;
      clr = (reg_wr && reg_wdata[15]) ? 1 : 0;
      go  = (reg_wr && reg_wdata[12] && m_busy == 0) ? 1 : 0;
      if (ev && (m_stat == 0 || clr)) m_cause = (gpio_change ? 2 : 0) + (sense_done ? 1 : 0);
      else if (clr) m_cause = 0;
      if (ev) m_stat = 1; else if (clr) m_stat = 0;
      m_start = go;
      if (go) m_busy = 1; else if (sense_done) m_busy = 0;
      if (reg_wr) begin
        m_en = reg_wdata[11] ? 1 : 0;
        m_page = reg_wdata[3:0];
      end
    end
  end

  function automatic logic [15:0] exp_word();
    return {m_stat[0], m_cause[1:0], m_busy[0], m_en[0], 7'b0, m_page[3:0]};
  endfunction

  task automatic compare(string tag);
    total++;
    if (reg_rdata !== exp_word()) begin
      bad++;
      $display("FAIL %s rdata actual=%h expected=%h", tag, reg_rdata, exp_word());
    end
    total++;
    if (sense_start !== m_start[0]) begin
      bad++;
      $display("FAIL %s sense_start actual=%b expected=%b", tag, sense_start, m_start[0]);
    end
    total++;
    if (slot12_gpi !== (m_stat[0] & m_en[0])) begin
      bad++;
      $display("FAIL %s slot12_gpi actual=%b expected=%b", tag, slot12_gpi, m_stat[0] & m_en[0]);
    end
  endtask

  // drive at negedge, let one edge pass, compare at the next negedge
  task automatic cyc(bit wr, logic [15:0] wd, bit sd, bit gc, string tag);
    reg_wr = wr; reg_wdata = wd; sense_done = sd; gpio_change = gc;
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) cyc(0, 16'h0, 0, 0, tag);
  endtask

  task automatic expect_word(logic [15:0] v, string tag);
    total++;
    if (reg_rdata !== v) begin
      bad++;
      $display("FAIL %s explicit actual=%h expected=%h", tag, reg_rdata, v);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    compare("R1");
    expect_word(16'h0000, "R1");
    rst_n = 1'b1;
    idle(2, "R1");

    // R2: masked event still sets pending; R4 sense-only cause 01
    cyc(0, 16'h0, 1, 0, "R2");
    expect_word(16'hA000, "R4");
    // R5: later GPIO event keeps cause
    cyc(0, 16'h0, 0, 1, "R5");
    expect_word(16'hA000, "R5");
    // R3: write 0 to bit 15 leaves status; R10/R9 load page and enable
    cyc(1, 16'h0005, 0, 0, "R10");
    expect_word(16'hA005, "R3");
    // R9: enable gates onto slot 12
    cyc(1, 16'h0807, 0, 0, "R9");
    total++;
    if (slot12_gpi !== 1'b1) begin bad++; $display("FAIL R9 gpi actual=%b expected=1", slot12_gpi); end
    // R3: clear
    cyc(1, 16'h8807, 0, 0, "R3");
    expect_word(16'h0807, "R3");
    // R4: GPIO-only then both
    cyc(0, 16'h0, 0, 1, "R4");
    expect_word(16'hC807, "R4");
    cyc(1, 16'h8807, 0, 0, "R3");
    cyc(0, 16'h0, 1, 1, "R4");
    expect_word(16'hE807, "R4");
    // R6: event in same cycle as clear
    cyc(1, 16'h8803, 0, 1, "R6");
    expect_word(16'hC803, "R6");
    // R11: reserved bits written with ones read zero
    cyc(1, 16'h87F0, 0, 0, "R11");
    expect_word(16'h0000, "R11");
    // R7: start sense
    cyc(1, 16'h1002, 0, 0, "R7");
    total++;
    if (sense_start !== 1'b1) begin bad++; $display("FAIL R7 start actual=%b expected=1", sense_start); end
    cyc(0, 16'h0, 0, 0, "R7");
    expect_word(16'h0000 | 16'h1002, "R7");
    // R8: restart while busy, and writing 0 to bit 12
    cyc(1, 16'h1002, 0, 0, "R8");
    cyc(1, 16'h0002, 0, 0, "R8");
    expect_word(16'h1002, "R8");
    // done ends the cycle and raises a sense event
    cyc(0, 16'h0, 1, 0, "R7");
    expect_word(16'hA002, "R7");
    // start and done together while idle: start wins
    cyc(1, 16'h9002, 1, 0, "R8");
    cyc(0, 16'h0, 1, 0, "R7");
    idle(2, "R7");

    // pseudo-random sweep against the model
    for (int i = 0; i < 400; i++) begin
      logic [15:0] w;
      w = 16'($urandom);
      cyc(($urandom % 3) == 0, w, ($urandom % 5) == 0, ($urandom % 6) == 0, "R2");
    end

    rst_n = 1'b0;
    @(negedge clk);
    compare("R1");
    expect_word(16'h0000, "R1");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule